// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames on a single line. Each frame is a low start bit, the data byte least significant bit first, an optional ninth data bit, and a high stop bit. A one-entry holding register sits in front of the shift engine. While a frame is still shifting out, software can park the next character in that register. The parked character then leaves right behind the current stop bit, with no idle gap.

Buffering can be switched off. The block then acts as a classic single-buffered transmitter. A write is accepted only when no data is being shifted. The ninth bit is read live from its input at the moment that bit goes out. The transmit flag rises when the stop bit begins.

With buffering on, the ninth bit is latched along with the byte at the moment of the write. The transmit flag then means that the holding register has become free. The baud rate comes from an external tick: each bit lasts a fixed number of ticks.

Top module: `uart_dbtx`

## Requirements
- R1: After reset, `txd` is 1, `tx_irq` is 0 and `overrun` is 0.
- R2: A frame is start bit 0, then `wr_data` bit 0 through bit 7, then the ninth bit only when `mode[1]` is 1, then stop bit 1. The `mode` encoding is: 2'b01 for 8-bit frames, 2'b10 or 2'b11 for 9-bit frames, and 2'b00 for the synchronous-shift setting, which sends 8-bit frames. The line idles at 1.
- R3: Every bit lasts exactly 16 baud ticks. `txd` changes only on a clock edge where `baud_tick` is high.
- R4: Buffering is active when `dbuf_en` is 1 and `mode` is not 2'b00. In that case, a byte written while a frame is in progress is held. Its frame starts on the tick that ends the current stop bit, so the two start edges are exactly one frame length apart.
- R5: With buffering active, `tx_irq` is set on the cycle the holding register passes its content to the shift engine. A full holding register sets no flag until that transfer happens.
- R6: With buffering active, the ninth bit sent is the value of `bit9_in` at the cycle of the write. Later changes to `bit9_in` have no effect on that frame.
- R7: With buffering inactive, `tx_irq` is set at the start of the stop bit. It is not set when a frame starts. A write is accepted only while the shift engine is idle or in its stop bit.
- R8: With buffering inactive, the ninth bit sent is the value of `bit9_in` on the tick where that bit position begins.
- R9: With `mode` at 2'b00, `dbuf_en` has no effect and the block behaves as described in R7.
- R10: `tx_irq` stays set until a cycle with `irq_clr` high clears it. A set event in the same cycle as a clear wins.
- R11: A write with no room is dropped, and its byte is never sent. No room means: holding register full with buffering active, or holding register full or data bits in progress with buffering inactive. A dropped write sets `overrun`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| bit9_in | input | 1 | Ninth data bit value |
| mode | input | 2 | Frame format select (see R2) |
| dbuf_en | input | 1 | Holding register enable |
| baud_tick | input | 1 | Baud tick, 16 per bit |
| irq_clr | input | 1 | Clears the transmit flag |
| txd | output | 1 | Serial line, idle high |
| tx_irq | output | 1 | Transmit flag |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The assertions check rules that hold on every cycle:
- the line stays high while idle and low after a load;
- `txd` changes only on ticks, and the stop bit is high;
- a full holding register keeps its content;
- a drop always sets `overrun`;
- with buffering active, a transfer always sets the flag, and the flag holds until a clear.

Other behaviour needs whole scenarios, so only the bench can show it:
- the bit order and timing of complete frames at two tick rates;
- that the live ninth bit and the latched ninth bit come from different cycles;
- the exact one-frame spacing of back-to-back frames;
- that a dropped byte never appears on the line;
- that `mode` 2'b00 overrides `dbuf_en`.

// File: rtl/uart_dbtx_pkg.sv
package uart_dbtx_pkg;

  // Frame format select encoding
  localparam logic [1:0] MODE_SHIFT = 2'b00;
  localparam logic [1:0] MODE_8BIT  = 2'b01;

  // Ninth data bit present for both 9-bit encodings
  function automatic logic mode_has_ninth(input logic [1:0] m);
    return m[1];
  endfunction

  // Holding register is only usable in the asynchronous formats
  function automatic logic mode_allows_hold(input logic [1:0] m);
    return m != MODE_SHIFT;
  endfunction

endpackage

// File: rtl/uart_dbtx_hold.sv
module uart_dbtx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              wr_ninth,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_bit9,
  output logic              hold_ninth
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              bit9_q;
  logic              ninth_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= 1'b0;
      data_q  <= '0;
      bit9_q  <= 1'b0;
      ninth_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q  <= 1'b1;
      data_q  <= wr_data;
      bit9_q  <= wr_bit9;
      ninth_q <= wr_ninth;
    end
  end

  assign full       = full_q;
  assign hold_data  = data_q;
  assign hold_bit9  = bit9_q;
  assign hold_ninth = ninth_q;

  AST_HOLD_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (full_q && !take) |=> (full_q && $stable(data_q) && $stable(bit9_q))); // R11
  AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    take |-> full_q); // R4

endmodule

// File: rtl/uart_dbtx_shifter.sv
module uart_dbtx_shifter #(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_bit9,
  input  logic              ld_ninth,
  input  logic              ld_live,
  input  logic              live_bit9,
  output logic              txd,
  output logic              data_phase,
  output logic              free_next,
  output logic              stop_start
);

  localparam int CNT_W = (OS > 1) ? $clog2(OS) : 1;
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OS - 1);
  localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] NINTH_IDX = IDX_W'(DATA_W + 1);

  logic              act_q;
  logic              txd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              bit9_q;
  logic              ninth_q;
  logic              live_q;

  logic [IDX_W-1:0]  stop_idx;
  logic [IDX_W-1:0]  idx_nx;
  logic              bit_end;
  logic              next_bit;

  always_comb begin
    stop_idx = ninth_q ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
    idx_nx   = idx_q + IDX_W'(1);
    bit_end  = baud_tick && act_q && (cnt_q == CNT_LAST);
    if (idx_nx <= DATA_LAST)
      next_bit = sh_q[0];
    else if (ninth_q && (idx_nx == NINTH_IDX))
      next_bit = live_q ? live_bit9 : bit9_q;
    else
      next_bit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      txd_q   <= 1'b1;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      bit9_q  <= 1'b0;
      ninth_q <= 1'b0;
      live_q  <= 1'b0;
    end else if (baud_tick) begin
      if (load) begin
        act_q   <= 1'b1;
        txd_q   <= 1'b0;
        cnt_q   <= '0;
        idx_q   <= '0;
        sh_q    <= ld_data;
        bit9_q  <= ld_bit9;
        ninth_q <= ld_ninth;
        live_q  <= ld_live;
      end else if (act_q) begin
        if (cnt_q == CNT_LAST) begin
          cnt_q <= '0;
          if (idx_q == stop_idx) begin
            act_q <= 1'b0;
            txd_q <= 1'b1;
          end else begin
            idx_q <= idx_nx;
            txd_q <= next_bit;
            if (idx_nx <= DATA_LAST)
              sh_q <= sh_q >> 1;
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign txd        = txd_q;
  assign data_phase = act_q && (idx_q != stop_idx);
  assign free_next  = !act_q || ((idx_q == stop_idx) && (cnt_q == CNT_LAST));
  assign stop_start = bit_end && (idx_nx == stop_idx);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> txd_q); // R2
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    load |=> (!txd_q && act_q)); // R2
  AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (rst)
    stop_start |=> txd_q); // R2
  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !baud_tick |=> $stable(txd_q)); // R3

endmodule

// File: rtl/uart_dbtx_flags.sv
module uart_dbtx_flags (
  input  logic clk,
  input  logic rst,
  input  logic irq_set,
  input  logic irq_clr,
  input  logic drop,
  output logic tx_irq,
  output logic overrun
);

  logic irq_q;
  logic ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (irq_set)
        irq_q <= 1'b1;
      else if (irq_clr)
        irq_q <= 1'b0;
      if (drop)
        ovr_q <= 1'b1;
    end
  end

  assign tx_irq  = irq_q;
  assign overrun = ovr_q;

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_clr) |=> irq_q); // R10
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !irq_set) |=> !irq_q); // R10
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovr_q |=> ovr_q); // R11

endmodule

// File: rtl/uart_dbtx.sv
module uart_dbtx
  import uart_dbtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit9_in,
  input  logic [1:0]        mode,
  input  logic              dbuf_en,
  input  logic              baud_tick,
  input  logic              irq_clr,
  output logic              txd,
  output logic              tx_irq,
  output logic              overrun
);

  logic              eff_dbuf;
  logic              accept;
  logic              drop;
  logic              load;
  logic              irq_set;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_bit9;
  logic              hold_ninth;
  logic              sh_data_phase;
  logic              sh_free_next;
  logic              sh_stop_start;

  always_comb begin
    eff_dbuf = dbuf_en && mode_allows_hold(mode);
    accept   = wr_en && !hold_full && (eff_dbuf || !sh_data_phase);
    drop     = wr_en && !accept;
    load     = baud_tick && hold_full && sh_free_next;
    irq_set  = eff_dbuf ? load : sh_stop_start;
  end

  uart_dbtx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .wr_data    (wr_data),
    .wr_bit9    (bit9_in),
    .wr_ninth   (mode_has_ninth(mode)),
    .take       (load),
    .full       (hold_full),
    .hold_data  (hold_data),
    .hold_bit9  (hold_bit9),
    .hold_ninth (hold_ninth)
  );

  uart_dbtx_shifter #(.DATA_W(DATA_W), .OS(OS)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .load       (load),
    .ld_data    (hold_data),
    .ld_bit9    (hold_bit9),
    .ld_ninth   (hold_ninth),
    .ld_live    (!eff_dbuf),
    .live_bit9  (bit9_in),
    .txd        (txd),
    .data_phase (sh_data_phase),
    .free_next  (sh_free_next),
    .stop_start (sh_stop_start)
  );

  uart_dbtx_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .irq_set (irq_set),
    .irq_clr (irq_clr),
    .drop    (drop),
    .tx_irq  (tx_irq),
    .overrun (overrun)
  );

  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !accept) |=> overrun); // R11
  AST_DBUF_IRQ_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (eff_dbuf && load) |=> tx_irq); // R5
  AST_SINGLE_NO_IRQ_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!eff_dbuf && load && !tx_irq) |=> !tx_irq); // R7

endmodule

// File: tb/uart_dbtx_bench.sv
module uart_dbtx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       bit9_in = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       dbuf_en = 1'b0;
  logic       baud_tick = 1'b0;
  logic       irq_clr = 1'b0;
  logic       txd;
  logic       tx_irq;
  logic       overrun;

  typedef struct {
    logic [7:0] data;
    logic       ninth;
    logic       b9;
    string      req;
  } frame_t;

  frame_t exp_q[$];
  int     starts[$];
  int     n_checks = 0;
  int     n_fail = 0;
  bit     finished = 0;
  int     tdiv = 1;
  int     tphase = 0;
  int     cyc = 0;
  event   ev_start;

  uart_dbtx u_uart_dbtx (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .bit9_in(bit9_in),
    .mode(mode), .dbuf_en(dbuf_en), .baud_tick(baud_tick), .irq_clr(irq_clr),
    .txd(txd), .tx_irq(tx_irq), .overrun(overrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(negedge clk);
    tphase = (tphase + 1 >= tdiv) ? 0 : tphase + 1;
    baud_tick = (tphase == 0);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Scoreboard monitor: pops the expected frame at each start edge
  logic        mon_prev = 1'b1;
  logic [10:0] mon_got;
  logic [10:0] mon_exp;
  int          mon_nb;
  frame_t      mon_e;

  initial forever begin
    @(negedge clk);
    if (rst) begin
      mon_prev = 1'b1;
    end else if (mon_prev && !txd) begin
      starts.push_back(cyc);
      -> ev_start;
      if (exp_q.size() == 0) begin
        check(0, "R11", "unexpected frame on line", 1, 0);
        repeat (10 * 16 * tdiv) @(negedge clk);
      end else begin
        mon_e   = exp_q.pop_front();
        mon_nb  = mon_e.ninth ? 11 : 10;
        mon_got = '1;
        mon_exp = '1;
        mon_exp[0]   = 1'b0;
        mon_exp[8:1] = mon_e.data;
        if (mon_e.ninth) mon_exp[9] = mon_e.b9;
        repeat (8 * tdiv) @(negedge clk);
        mon_got[0] = txd;
        for (int k = 1; k < mon_nb; k++) begin
          repeat (16 * tdiv) @(negedge clk);
          mon_got[k] = txd;
        end
        check(mon_got == mon_exp, mon_e.req, "frame bits", int'(mon_got), int'(mon_exp));
      end
      mon_prev = txd;
    end else begin
      mon_prev = txd;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    report();
  end

  task automatic expect_frame(input logic [7:0] d, input logic ninth,
                              input logic b9, input string req);
    frame_t f;
    f.data = d; f.ninth = ninth; f.b9 = b9; f.req = req;
    exp_q.push_back(f);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (12 * 16 * tdiv) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R1", "txd after reset", txd, 1);
    check(tx_irq == 1'b0, "R1", "tx_irq after reset", tx_irq, 0);
    check(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);

    // Single-buffered 8-bit frame, flag at stop bit start
    mode = 2'b01; dbuf_en = 1'b0;
    expect_frame(8'hA5, 1'b0, 1'b0, "R2");
    write_byte(8'hA5);
    @(ev_start);
    repeat (100) @(negedge clk);
    check(tx_irq == 1'b0, "R7", "flag before stop bit", tx_irq, 0);
    repeat (50) @(negedge clk);
    check(tx_irq == 1'b1, "R7", "flag in stop bit", tx_irq, 1);
    drain();
    check(tx_irq == 1'b1, "R10", "flag held after frame", tx_irq, 1);
    check(txd == 1'b1, "R2", "line idles high", txd, 1);
    pulse_clear();
    check(tx_irq == 1'b0, "R10", "flag cleared by strobe", tx_irq, 0);

    // Single-buffered 9-bit: ninth bit sampled live; write during data dropped
    mode = 2'b10; bit9_in = 1'b0;
    expect_frame(8'h3C, 1'b1, 1'b1, "R8");
    write_byte(8'h3C);
    @(ev_start);
    repeat (40) @(negedge clk);
    bit9_in = 1'b1;
    write_byte(8'h77);
    check(overrun == 1'b1, "R11", "overrun after write during data", overrun, 1);
    drain();
    check(txd == 1'b1, "R11", "line idle, dropped byte not sent", txd, 1);
    do_reset();
    check(overrun == 1'b0, "R11", "overrun cleared only by reset", overrun, 0);

    // Buffered 9-bit: latched ninth bit, flag on transfer, back-to-back frames
    mode = 2'b10; dbuf_en = 1'b1; bit9_in = 1'b1;
    expect_frame(8'h81, 1'b1, 1'b1, "R6");
    write_byte(8'h81);
    @(ev_start);
    check(tx_irq == 1'b1, "R5", "flag when holding register frees", tx_irq, 1);
    pulse_clear();
    bit9_in = 1'b0;
    expect_frame(8'h42, 1'b1, 1'b0, "R6");
    write_byte(8'h42);
    bit9_in = 1'b1;
    repeat (20) @(negedge clk);
    check(tx_irq == 1'b0, "R5", "no flag while holding register full", tx_irq, 0);
    write_byte(8'h99);
    check(overrun == 1'b1, "R11", "overrun with holding register full", overrun, 1);
    @(ev_start);
    check(tx_irq == 1'b1, "R5", "flag on second transfer", tx_irq, 1);
    drain();
    check(starts.size() >= 2 && (starts[starts.size()-1] - starts[starts.size()-2]) == 176,
          "R4", "start spacing back-to-back",
          starts[starts.size()-1] - starts[starts.size()-2], 176);

    // Shift-mode setting overrides the buffer enable
    do_reset();
    mode = 2'b00; dbuf_en = 1'b1;
    expect_frame(8'h5A, 1'b0, 1'b0, "R9");
    write_byte(8'h5A);
    @(ev_start);
    repeat (5) @(negedge clk);
    check(tx_irq == 1'b0, "R9", "no flag at frame start", tx_irq, 0);
    repeat (15) @(negedge clk);
    write_byte(8'h11);
    check(overrun == 1'b1, "R9", "write during data dropped", overrun, 1);
    drain();
    check(tx_irq == 1'b1, "R9", "flag from stop bit", tx_irq, 1);

    // Slower tick rate: each bit is 16 ticks
    pulse_clear();
    mode = 2'b01; dbuf_en = 1'b0; tdiv = 3;
    expect_frame(8'hC3, 1'b0, 1'b0, "R3");
    write_byte(8'hC3);
    @(ev_start);
    repeat (40) @(negedge clk);
    check(txd == 1'b0, "R3", "start bit still low after 40 clocks", txd, 0);
    drain();

    report();
  end

endmodule